// File: doc/BRIEF.md
# Horizontal Sync Processing Unit

This block conditions the horizontal sync of a video digitizer. It runs in the pixel clock domain. It takes two candidate raw sync inputs, synchronizes them and selects one. The selection is either made by the block or forced by configuration. The block then works out which level of the selected input is the active one and produces a one-cycle strobe on each leading edge.

All downstream timing hangs off two points. The leading edge starts a regenerated sync pulse, whose width and output sense are programmable. The trailing edge arms a clamp window, placed by a delay and a duration, both counted in pixel clocks. A leading edge cancels any clamp delay or window still in progress. An external clamp mode bypasses the internal window and routes an external clamp input straight to the clamp output. All configuration fields are plain input ports, held by a register file elsewhere.

Top module: `hsync_proc`

## Requirements
- R1: Each sync input passes through two flops before any edge is seen. The leading-edge strobe `lead_strobe` is high for exactly one cycle per leading edge, never on two cycles in a row.
- R2: The leading edge is the rising edge of the selected synchronized input when the effective polarity is active high (1), and the falling edge when it is active low (0).
- R3: With `pol_force` = 1, the effective polarity is `pol_user` (0 active low, 1 active high). With `pol_force` = 0, it is the detected polarity.
- R4: `pol_detected` resets to 1 and changes only on a rising edge of the selected input. At that edge it becomes 1 if the input spent fewer cycles high than low since the previous rising edge, and 0 if it spent more. On a tie it holds. Both cycle counts saturate at 4095.
- R5: The cycle after a leading-edge strobe, the regenerated pulse is asserted for exactly `out_width` cycles (0 gives no pulse). A new leading edge reloads the count.
- R6: With `out_pol` = 0, `hsync_out` is 1 while asserted and 0 otherwise. With `out_pol` = 1, both levels are inverted.
- R7: Count from the cycle after a trailing-edge strobe. `clamp_out` then stays low for `clamp_delay` cycles and is high for the next `clamp_len` cycles (1 to 255). A leading edge cancels a pending or running window.
- R8: With `ext_clamp_mode` = 1, `clamp_out` equals `ext_clamp_in` in the same cycle, and the internal delay and duration have no effect on it.
- R9: With `src_force` = 1, `src_sel` picks the sync input (0 selects `hs_a_in`, 1 selects `hs_b_in`). With `src_force` = 0, input A is used unless A has not toggled for ACT_TIMEOUT cycles while B has.
- R10: The trailing edge of the input has no effect on the regenerated pulse. A pulse wider than the active part of the input runs to its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_a_in | input | 1 | Raw sync candidate A |
| hs_b_in | input | 1 | Raw sync candidate B |
| ext_clamp_in | input | 1 | External clamp signal |
| pol_force | input | 1 | 1: input polarity from pol_user |
| pol_user | input | 1 | Forced input polarity, 1 active high |
| src_force | input | 1 | 1: sync source from src_sel |
| src_sel | input | 1 | Forced source, 0 A, 1 B |
| ext_clamp_mode | input | 1 | 1: clamp output follows ext_clamp_in |
| clamp_delay | input | 8 | Clamp start delay after trailing edge, cycles |
| clamp_len | input | 8 | Clamp window length, cycles |
| out_width | input | 8 | Regenerated pulse width, cycles |
| out_pol | input | 1 | 1 inverts the sync output |
| hsync_out | output | 1 | Regenerated sync pulse |
| clamp_out | output | 1 | Clamp window |
| lead_strobe | output | 1 | One-cycle leading-edge strobe |
| pol_detected | output | 1 | Auto-detected polarity, 1 active high |

## Verification
Lines are driven with a short active-high pulse, and then with a short active-low pulse. This shows whether timing follows the leading edge, and whether detection flips only at line boundaries. Forcing the polarity against the real input moves every edge to the opposite transition, which separates the forced path from the detected one. Wide pulses, zero width and short lines test reload and cancel against a plain countdown. A quiet input A beside an active B exercises the timeout-based source choice in both directions.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  typedef enum logic [1:0] {
    CL_IDLE  = 2'd0,
    CL_DELAY = 2'd1,
    CL_WIN   = 2'd2
  } clamp_st_e;
endpackage

// File: rtl/hsp_sync.sv
`timescale 1ns/1ps
module hsp_sync #(
  parameter int N_IN        = 2,
  parameter int ACT_TIMEOUT = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] d_in,
  output logic [N_IN-1:0] d_sync,
  output logic [N_IN-1:0] alive
);
  localparam int AGE_W = $clog2(ACT_TIMEOUT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ACT_TIMEOUT);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic             meta_q, stab_q, last_q;
    logic [AGE_W-1:0] age_q, age_d;

    always_comb begin
      if (stab_q != last_q)      age_d = '0;
      else if (age_q != AGE_MAX) age_d = age_q + 1'b1;
      else                       age_d = age_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        last_q <= 1'b0;
        age_q  <= AGE_MAX;
      end else begin
        meta_q <= d_in[i];
        stab_q <= meta_q;
        last_q <= stab_q;
        age_q  <= age_d;
      end
    end

    assign d_sync[i] = stab_q;
    assign alive[i]  = (age_q != AGE_MAX);
  end
endmodule

// File: rtl/hsp_pol_detect.sv
`timescale 1ns/1ps
module hsp_pol_detect #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise,
  output logic pol_hi
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic             pol_d;

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    pol_d = pol_hi;
    if (rise) begin
      if (hi_q < lo_q)      pol_d = 1'b1;
      else if (hi_q > lo_q) pol_d = 1'b0;
      hi_d = CNT_W'(1);
      lo_d = '0;
    end else if (level) begin
      if (hi_q != CMAX) hi_d = hi_q + 1'b1;
    end else begin
      if (lo_q != CMAX) lo_d = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      pol_hi <= 1'b1;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      pol_hi <= pol_d;
    end
  end
endmodule

// File: rtl/hsp_pulse_gen.sv
`timescale 1ns/1ps
module hsp_pulse_gen #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead,
  input  logic [REG_W-1:0] width,
  input  logic             inv,
  output logic             pulse_out
);
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = lead || (cnt_q != '0);

  always_comb begin
    if (lead) cnt_d = width;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_out = (cnt_q != '0) ^ inv;
endmodule

// File: rtl/hsp_clamp_gen.sv
`timescale 1ns/1ps
module hsp_clamp_gen
  import hsp_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead,
  input  logic             trail,
  input  logic [REG_W-1:0] delay,
  input  logic [REG_W-1:0] len,
  output logic             window
);
  clamp_st_e        st_q, st_d;
  logic [REG_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (lead) begin
      st_d  = CL_IDLE;
      cnt_d = '0;
    end else if (trail) begin
      if (delay == '0) begin
        st_d  = CL_WIN;
        cnt_d = len;
      end else begin
        st_d  = CL_DELAY;
        cnt_d = delay;
      end
    end else begin
      case (st_q)
        CL_DELAY: begin
          if (cnt_q <= REG_W'(1)) begin
            st_d  = CL_WIN;
            cnt_d = len;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        CL_WIN: begin
          if (cnt_q <= REG_W'(1)) begin
            st_d  = CL_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          st_d  = CL_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CL_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign window = (st_q == CL_WIN);
endmodule

// File: rtl/hsync_proc.sv
`timescale 1ns/1ps
module hsync_proc #(
  parameter int REG_W       = 8,
  parameter int CNT_W       = 12,
  parameter int ACT_TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_a_in,
  input  logic             hs_b_in,
  input  logic             ext_clamp_in,
  input  logic             pol_force,
  input  logic             pol_user,
  input  logic             src_force,
  input  logic             src_sel,
  input  logic             ext_clamp_mode,
  input  logic [REG_W-1:0] clamp_delay,
  input  logic [REG_W-1:0] clamp_len,
  input  logic [REG_W-1:0] out_width,
  input  logic             out_pol,
  output logic             hsync_out,
  output logic             clamp_out,
  output logic             lead_strobe,
  output logic             pol_detected
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw, syn, alive;
  logic            use_b, s_cur, s_prev, eff_pol;
  logic            lead, trail, rise, clamp_int;

  assign raw = {hs_b_in, hs_a_in};

  hsp_sync #(.N_IN(N_IN), .ACT_TIMEOUT(ACT_TIMEOUT)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (raw),
    .d_sync (syn),
    .alive  (alive)
  );

  always_comb begin
    use_b = src_force ? src_sel : (!alive[0] && alive[1]);
    s_cur = use_b ? syn[1] : syn[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_cur;
  end

  always_comb begin
    rise    = s_cur && !s_prev;
    eff_pol = pol_force ? pol_user : pol_detected;
    lead    = eff_pol ? rise : (!s_cur && s_prev);
    trail   = eff_pol ? (!s_cur && s_prev) : rise;
  end

  hsp_pol_detect #(.CNT_W(CNT_W)) u_pol (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (s_cur),
    .rise   (rise),
    .pol_hi (pol_detected)
  );

  hsp_pulse_gen #(.REG_W(REG_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .lead      (lead),
    .width     (out_width),
    .inv       (out_pol),
    .pulse_out (hsync_out)
  );

  hsp_clamp_gen #(.REG_W(REG_W)) u_clamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .lead   (lead),
    .trail  (trail),
    .delay  (clamp_delay),
    .len    (clamp_len),
    .window (clamp_int)
  );

  assign clamp_out   = ext_clamp_mode ? ext_clamp_in : clamp_int;
  assign lead_strobe = lead;
endmodule

// File: rtl/hsp_chk.sv
`timescale 1ns/1ps
module hsp_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_clamp_mode,
  input logic [REG_W-1:0] out_width,
  input logic             out_pol,
  input logic             hsync_out,
  input logic             clamp_out,
  input logic             lead_strobe
);
  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lead_strobe |=> !lead_strobe); // R1

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_strobe && out_width != '0) |=> (hsync_out ^ out_pol)); // R5

  AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_strobe && out_width == '0) |=> !(hsync_out ^ out_pol)); // R5

  AST_CLAMP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_strobe && !ext_clamp_mode) |=> (ext_clamp_mode || !clamp_out)); // R7
endmodule

bind hsync_proc hsp_chk #(.REG_W(REG_W)) i_hsp_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ext_clamp_mode (ext_clamp_mode),
  .out_width      (out_width),
  .out_pol        (out_pol),
  .hsync_out      (hsync_out),
  .clamp_out      (clamp_out),
  .lead_strobe    (lead_strobe)
);

// File: tb/test_hsync_proc.sv
`timescale 1ns/1ps
module test_hsync_proc;
  localparam int TO   = 64;
  localparam int CMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_a_in = 1'b0, hs_b_in = 1'b0, ext_clamp_in = 1'b0;
  logic pol_force = 1'b0, pol_user = 1'b1, src_force = 1'b0, src_sel = 1'b0;
  logic ext_clamp_mode = 1'b0, out_pol = 1'b0;
  logic [7:0] clamp_delay = 8'd3, clamp_len = 8'd8, out_width = 8'd5;
  logic hsync_out, clamp_out, lead_strobe, pol_detected;

  always #5 clk = ~clk;

  hsync_proc #(.ACT_TIMEOUT(TO)) i_hsync_proc (
    .clk(clk), .rst_n(rst_n), .hs_a_in(hs_a_in), .hs_b_in(hs_b_in),
    .ext_clamp_in(ext_clamp_in), .pol_force(pol_force), .pol_user(pol_user),
    .src_force(src_force), .src_sel(src_sel), .ext_clamp_mode(ext_clamp_mode),
    .clamp_delay(clamp_delay), .clamp_len(clamp_len), .out_width(out_width),
    .out_pol(out_pol), .hsync_out(hsync_out), .clamp_out(clamp_out),
    .lead_strobe(lead_strobe), .pol_detected(pol_detected));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_a1, m_a2, m_a3, m_b1, m_b2, m_b3, m_sd, m_pol, m_arm;
  int m_age_a, m_age_b, m_hi, m_lo, m_out, m_t;

  function automatic bit m_cur();
    bit useb;
    useb = src_force ? src_sel : (!(m_age_a < TO) && (m_age_b < TO));
    return useb ? m_b2 : m_a2;
  endfunction

  function automatic bit m_epol();
    return pol_force ? pol_user : m_pol;
  endfunction

  function automatic bit m_lead();
    bit s;
    s = m_cur();
    return m_epol() ? (s && !m_sd) : (!s && m_sd);
  endfunction

  function automatic bit m_trail();
    bit s;
    s = m_cur();
    return m_epol() ? (!s && m_sd) : (s && !m_sd);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_b1 = 0; m_b2 = 0; m_b3 = 0;
      m_sd = 0; m_pol = 1; m_arm = 0; m_age_a = TO; m_age_b = TO;
      m_hi = 0; m_lo = 0; m_out = 0; m_t = 0;
    end else begin
      bit s, ld, tr;
      s  = m_cur();
      ld = m_lead();
      tr = m_trail();
      if (s && !m_sd) begin
        if (m_hi < m_lo) m_pol = 1;
        else if (m_hi > m_lo) m_pol = 0;
        m_hi = 1; m_lo = 0;
      end else if (s) begin
        if (m_hi < CMAX) m_hi++;
      end else if (m_lo < CMAX) m_lo++;
      if (ld) m_out = out_width;
      else if (m_out > 0) m_out--;
      if (ld) m_arm = 0;
      else if (tr) begin m_arm = 1; m_t = 1; end
      else if (m_arm) begin
        m_t++;
        if (m_t > clamp_delay + clamp_len) m_arm = 0;
      end
      m_sd = s;
      if (m_a2 != m_a3) m_age_a = 0; else if (m_age_a < TO) m_age_a++;
      if (m_b2 != m_b3) m_age_b = 0; else if (m_age_b < TO) m_age_b++;
      m_a3 = m_a2; m_a2 = m_a1; m_a1 = hs_a_in;
      m_b3 = m_b2; m_b2 = m_b1; m_b1 = hs_b_in;
    end
  end

  task automatic chk(input string what, input bit got, input bit exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("lead_strobe (R1 R2)", lead_strobe, m_lead());
      chk("hsync_out (R5 R6 R10)", hsync_out, (m_out > 0) ^ out_pol);
      chk("clamp_out (R7 R8)", clamp_out,
          ext_clamp_mode ? ext_clamp_in : (m_arm && (m_t > clamp_delay)));
      chk("pol_detected (R3 R4)", pol_detected, m_pol);
    end
  end

  task automatic run_line(input bit on_b, input bit act_hi, input int act_len, input int period);
    for (int i = 0; i < period; i++) begin
      @(posedge clk); #2;
      if (on_b) hs_b_in = (i < act_len) ? act_hi : !act_hi;
      else      hs_a_in = (i < act_len) ? act_hi : !act_hi;
      ext_clamp_in = ((i % 7) < 3);
    end
  endtask

  task automatic lines(input int n, input bit on_b, input bit act_hi, input int act_len, input int period);
    for (int k = 0; k < n; k++) run_line(on_b, act_hi, act_len, period);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    cur_req = "R4 R6";  // reset state
    chk("reset hsync_out R6", hsync_out, 1'b0);
    chk("reset clamp_out R7", clamp_out, 1'b0);
    chk("reset pol_detected R4", pol_detected, 1'b1);
    chk("reset lead_strobe R1", lead_strobe, 1'b0);
    rst_n = 1'b1;
    idle(3);

    cur_req = "R2";  // active-high lines, timing on rising edge
    lines(6, 1'b0, 1'b1, 6, 40);
    cur_req = "R4";  // active-low lines, detection flips at line boundary
    lines(6, 1'b0, 1'b0, 6, 40);
    cur_req = "R4";  // saturation of the level counters on a very long line
    run_line(1'b0, 1'b0, 4200, 4300);
    lines(3, 1'b0, 1'b0, 6, 40);

    cur_req = "R3";  // forced polarity against the real input
    pol_force = 1'b1; pol_user = 1'b1;
    lines(4, 1'b0, 1'b0, 6, 40);
    pol_user = 1'b0;
    lines(4, 1'b0, 1'b0, 6, 40);
    pol_force = 1'b0;
    lines(2, 1'b0, 1'b1, 6, 40);

    cur_req = "R6";
    out_pol = 1'b1;
    lines(4, 1'b0, 1'b1, 6, 40);
    out_pol = 1'b0;

    cur_req = "R5";  // reload by each new leading edge
    out_width = 8'd255;
    lines(4, 1'b0, 1'b1, 6, 40);
    idle(260);
    out_width = 8'd0;
    lines(3, 1'b0, 1'b1, 6, 40);
    cur_req = "R10";  // trailing edge inside the pulse
    out_width = 8'd30;
    lines(3, 1'b0, 1'b1, 6, 60);
    out_width = 8'd1;
    lines(2, 1'b0, 1'b1, 6, 40);
    out_width = 8'd5;

    cur_req = "R7";  // cancel by leading edge, then extremes
    clamp_delay = 8'd20; clamp_len = 8'd30;
    lines(4, 1'b0, 1'b1, 6, 40);
    idle(60);
    clamp_delay = 8'd0; clamp_len = 8'd1;
    lines(3, 1'b0, 1'b1, 6, 40);
    idle(10);
    clamp_len = 8'd255;
    lines(2, 1'b0, 1'b1, 6, 300);
    idle(300);
    clamp_delay = 8'd3; clamp_len = 8'd8;

    cur_req = "R8";
    ext_clamp_mode = 1'b1;
    lines(4, 1'b0, 1'b1, 6, 40);
    ext_clamp_mode = 1'b0;
    idle(20);

    cur_req = "R9";  // forced source B, then automatic fallback and return
    src_force = 1'b1; src_sel = 1'b1;
    lines(4, 1'b1, 1'b1, 8, 50);
    src_force = 1'b0;
    lines(6, 1'b1, 1'b1, 8, 50);
    lines(4, 1'b0, 1'b1, 6, 40);
    src_force = 1'b1; src_sel = 1'b0;
    lines(2, 1'b0, 1'b1, 6, 40);
    src_force = 1'b0;
    idle(20);

    summary();
  end
endmodule